// File: doc/BRIEF.md
# Exception Entry Control Unit

This unit performs the state changes a processor makes when it takes an exception. A general request arrives with a cause code, the faulting PC, the current status word and, optionally, a faulting virtual address. The unit then picks one of three general entry routes from the status word's exception-mode and user-mode flags. A debug request takes a separate route. That route applies only when the current interrupt level is below the configured debug level. It saves the whole status word for that level and raises the interrupt level.

Every register the unit owns is updated on the same clock edge. A one-hot vector select output pulses for that one cycle so the fetch logic can redirect. Together with the select, an updated status word is presented with a write strobe. The owner of the status register feeds its value back on the status input.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every output register, the status write strobe and the vector select are zero.
- R2: A general exception taken while status bit 4 (exception mode) is clear writes the faulting PC to the level-1 PC register. It selects the user vector (select bit 1) when status bit 5 (user mode) is set, and the kernel vector (select bit 0) when it is clear.
- R3: A general exception taken while status bit 4 is set writes the faulting PC to the double-exception PC register when HAS_DEPC=1, or to the level-1 PC register when HAS_DEPC=0. The level-1 PC register is left alone when HAS_DEPC=1. It selects the double vector (select bit 2).
- R4: Every general exception writes the cause code to the cause register. It presents the incoming status word with bit 4 set on the status output, with the write strobe high.
- R5: The faulting address register is written only by a general exception whose address-valid input is high. Otherwise it keeps its value.
- R6: A debug request is accepted only when status bits [3:0] (interrupt level) are strictly less than DEBUG_LEVEL. A refused debug request alone changes no register and produces no select pulse.
- R7: An accepted debug request writes the debug cause register and the debug-level PC register. It copies the incoming status word unchanged into the saved-status register.
- R8: On debug entry the status output equals the incoming status word with bits [3:0] replaced by DEBUG_LEVEL and bit 4 set. It selects the debug vector (select bit 3).
- R9: The select output is one-hot for exactly the cycle after the accepted request, coinciding with the status write strobe and the register updates. It is zero on idle cycles.
- R10: When a general and an accepted debug request coincide, only the debug route acts: the general registers are unchanged. When the debug request is refused, the general exception proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_req | input | 1 | General exception raise strobe |
| gen_cause | input | CAUSE_W | General cause code |
| gen_va_vld | input | 1 | Faulting address accompanies the request |
| gen_va | input | ADDR_W | Faulting virtual address |
| dbg_req | input | 1 | Debug exception raise strobe |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| fault_pc | input | ADDR_W | PC of the faulting instruction |
| ps_in | input | PS_W | Current status word |
| ps_out | output | PS_W | Updated status word |
| ps_we | output | 1 | Status write strobe, one cycle |
| vec_sel | output | 4 | One-hot vector select: kernel, user, double, debug |
| epc1 | output | ADDR_W | Level-1 exception PC |
| depc | output | ADDR_W | Double-exception PC |
| exccause | output | CAUSE_W | General cause register |
| excvaddr | output | ADDR_W | Faulting address register |
| dbgcause | output | DCAUSE_W | Debug cause register |
| epc_dbg | output | ADDR_W | Exception PC of the debug level |
| eps_dbg | output | PS_W | Saved status word of the debug level |

## Verification
The general route and the debug route can both be requested in the same cycle. The bench raises both together while sweeping the interrupt level through all sixteen values, with the exception-mode and user-mode flags varied. It decides from the level alone which route must win. When the level is below DEBUG_LEVEL, only the debug registers, the debug select bit and the debug status image may change. The cause, level-1 PC, double PC and address registers must keep their previous values. At or above the level, the outcome must equal the one a lone general request would have produced.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int PS_W     = 32;
  localparam int LVL_W    = 4;
  localparam int EXCM_POS = LVL_W;
  localparam int UM_POS   = LVL_W + 1;
  localparam int VEC_N    = 4;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  function automatic logic [PS_W-1:0] ps_mark_excm(input logic [PS_W-1:0] ps);
    logic [PS_W-1:0] r;
    r = ps;
    r[EXCM_POS] = 1'b1;
    return r;
  endfunction

  function automatic logic [PS_W-1:0] ps_enter_debug(input logic [PS_W-1:0] ps,
                                                      input logic [LVL_W-1:0] lvl);
    logic [PS_W-1:0] r;
    r = ps;
    r[LVL_W-1:0] = lvl;
    r[EXCM_POS]  = 1'b1;
    return r;
  endfunction

  function automatic logic dbg_eligible(input logic [PS_W-1:0] ps,
                                        input logic [LVL_W-1:0] lvl);
    return ps[LVL_W-1:0] < lvl;
  endfunction

  function automatic logic [VEC_N-1:0] vec_onehot(input vec_e v);
    return VEC_N'(1) << v;
  endfunction
endpackage

// File: rtl/exc_gen_path.sv
module exc_gen_path
  import exc_entry_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic [PS_W-1:0] ps,
  output vec_e            vec,
  output logic            pc_to_depc,
  output logic            pc_to_epc1
);
  logic nested;
  assign nested = ps[EXCM_POS];

  always_comb begin
    if (nested)            vec = VEC_DOUBLE;
    else if (ps[UM_POS])   vec = VEC_USER;
    else                   vec = VEC_KERNEL;
  end

  generate
    if (HAS_DEPC) begin : g_depc
      assign pc_to_depc = nested;
      assign pc_to_epc1 = !nested;
    end else begin : g_nodepc
      assign pc_to_depc = 1'b0;
      assign pc_to_epc1 = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/exc_dbg_path.sv
module exc_dbg_path
  import exc_entry_pkg::*;
#(
  parameter int DEBUG_LEVEL = 6
) (
  input  logic            req,
  input  logic [PS_W-1:0] ps,
  output logic            take,
  output logic [PS_W-1:0] ps_next
);
  localparam logic [LVL_W-1:0] LVL = LVL_W'(DEBUG_LEVEL);

  assign take    = req && dbg_eligible(ps, LVL);
  assign ps_next = ps_enter_debug(ps, LVL);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CAUSE_W     = 6,
  parameter int DCAUSE_W    = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter int DEBUG_LEVEL = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gen_req,
  input  logic [CAUSE_W-1:0]  gen_cause,
  input  logic                gen_va_vld,
  input  logic [ADDR_W-1:0]   gen_va,
  input  logic                dbg_req,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic [ADDR_W-1:0]   fault_pc,
  input  logic [PS_W-1:0]     ps_in,
  output logic [PS_W-1:0]     ps_out,
  output logic                ps_we,
  output logic [VEC_N-1:0]    vec_sel,
  output logic [ADDR_W-1:0]   epc1,
  output logic [ADDR_W-1:0]   depc,
  output logic [CAUSE_W-1:0]  exccause,
  output logic [ADDR_W-1:0]   excvaddr,
  output logic [DCAUSE_W-1:0] dbgcause,
  output logic [ADDR_W-1:0]   epc_dbg,
  output logic [PS_W-1:0]     eps_dbg
);
  vec_e            gen_vec;
  logic            pc_to_depc, pc_to_epc1;
  logic            dbg_take, gen_take;
  logic [PS_W-1:0] dbg_ps_next;

  exc_gen_path #(.HAS_DEPC(HAS_DEPC)) gen_i (
    .ps(ps_in), .vec(gen_vec), .pc_to_depc(pc_to_depc), .pc_to_epc1(pc_to_epc1)
  );

  exc_dbg_path #(.DEBUG_LEVEL(DEBUG_LEVEL)) dbg_i (
    .req(dbg_req), .ps(ps_in), .take(dbg_take), .ps_next(dbg_ps_next)
  );

  // debug route has priority over a coincident general request
  assign gen_take = gen_req && !dbg_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ps_out   <= '0;
      ps_we    <= 1'b0;
      vec_sel  <= '0;
      epc1     <= '0;
      depc     <= '0;
      exccause <= '0;
      excvaddr <= '0;
      dbgcause <= '0;
      epc_dbg  <= '0;
      eps_dbg  <= '0;
    end else begin
      ps_we   <= dbg_take || gen_take;
      vec_sel <= '0;
      if (dbg_take) begin
        dbgcause <= dbg_cause;
        epc_dbg  <= fault_pc;
        eps_dbg  <= ps_in;
        ps_out   <= dbg_ps_next;
        vec_sel  <= vec_onehot(VEC_DEBUG);
      end else if (gen_take) begin
        if (gen_va_vld) excvaddr <= gen_va;
        if (pc_to_depc) depc <= fault_pc;
        if (pc_to_epc1) epc1 <= fault_pc;
        exccause <= gen_cause;
        ps_out   <= ps_mark_excm(ps_in);
        vec_sel  <= vec_onehot(gen_vec);
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CAUSE_W     = 6,
  parameter bit HAS_DEPC    = 1'b1,
  parameter int DEBUG_LEVEL = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               gen_req,
  input logic               dbg_req,
  input logic [PS_W-1:0]    ps_in,
  input logic [PS_W-1:0]    ps_out,
  input logic               ps_we,
  input logic [VEC_N-1:0]   vec_sel,
  input logic [ADDR_W-1:0]  epc1,
  input logic [CAUSE_W-1:0] exccause,
  input logic               gen_take,
  input logic               dbg_take
);
  localparam logic [LVL_W-1:0] LVL = LVL_W'(DEBUG_LEVEL);

  assert_vec_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_sel));

  assert_vec_with_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_sel != '0) == ps_we);

  assert_req_gives_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_take || dbg_take) |=> ps_we);

  assert_gen_sets_excm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_sel[2:0] != 3'b000) |-> ps_out[EXCM_POS]);

  assert_dbg_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_sel[3] |-> (ps_out[LVL_W-1:0] == LVL && ps_out[EXCM_POS]));

  assert_dbg_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && ps_in[LVL_W-1:0] >= LVL && !gen_req) |=> !ps_we);

  assert_dbg_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_sel[3] |-> $stable(exccause));

  assert_epc1_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(epc1) |-> (vec_sel[0] || vec_sel[1] || (vec_sel[2] && !HAS_DEPC)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .HAS_DEPC(HAS_DEPC), .DEBUG_LEVEL(DEBUG_LEVEL)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .dbg_req(dbg_req), .ps_in(ps_in),
  .ps_out(ps_out), .ps_we(ps_we), .vec_sel(vec_sel), .epc1(epc1),
  .exccause(exccause), .gen_take(gen_take), .dbg_take(dbg_take)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  localparam int DL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_req = 1'b0, gen_va_vld = 1'b0, dbg_req = 1'b0;
  logic [5:0]  gen_cause = '0, dbg_cause = '0;
  logic [31:0] gen_va = '0, fault_pc = '0, ps_in = '0;
  logic [31:0] ps_out, epc1, depc, excvaddr, epc_dbg, eps_dbg;
  logic        ps_we;
  logic [3:0]  vec_sel;
  logic [5:0]  exccause, dbgcause;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] m_epc1 = 0, m_depc = 0, m_va = 0, m_epcd = 0, m_eps = 0, m_ps = 0;
  logic [5:0]  m_cause = 0, m_dcause = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_cause(gen_cause),
    .gen_va_vld(gen_va_vld), .gen_va(gen_va), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
    .fault_pc(fault_pc), .ps_in(ps_in), .ps_out(ps_out), .ps_we(ps_we),
    .vec_sel(vec_sel), .epc1(epc1), .depc(depc), .exccause(exccause),
    .excvaddr(excvaddr), .dbgcause(dbgcause), .epc_dbg(epc_dbg), .eps_dbg(eps_dbg)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string vtag, input logic [3:0] ev, input logic ew);
    chk(vtag, "vec_sel", {28'd0, vec_sel}, {28'd0, ev});
    chk("R9", "ps_we", {31'd0, ps_we}, {31'd0, ew});
    chk("R2", "epc1", epc1, m_epc1);
    chk("R3", "depc", depc, m_depc);
    chk("R4", "exccause", {26'd0, exccause}, {26'd0, m_cause});
    chk("R5", "excvaddr", excvaddr, m_va);
    chk("R7", "dbgcause", {26'd0, dbgcause}, {26'd0, m_dcause});
    chk("R7", "epc_dbg", epc_dbg, m_epcd);
    chk("R7", "eps_dbg", eps_dbg, m_eps);
    if (ew) chk(ev[3] ? "R8" : "R4", "ps_out", ps_out, m_ps);
  endtask

  // one request cycle: drive at negedge, result visible after the next posedge
  task automatic run(input string tag, input logic g, input logic [5:0] c,
                     input logic hv, input logic [31:0] va, input logic d,
                     input logic [5:0] dc, input logic [31:0] pc, input logic [31:0] ps);
    logic [3:0] ev;
    logic       ew;
    logic       dt;
    gen_req = g; gen_cause = c; gen_va_vld = hv; gen_va = va;
    dbg_req = d; dbg_cause = dc; fault_pc = pc; ps_in = ps;
    dt = d && (ps[3:0] < 4'(DL));
    ev = 4'b0000; ew = 1'b0;
    if (dt) begin
      m_dcause = dc; m_epcd = pc; m_eps = ps;
      m_ps = (ps & ~32'h1F) | 32'h10 | 32'(DL);
      ev = 4'b1000; ew = 1'b1;
    end else if (g) begin
      if (hv) m_va = va;
      m_cause = c;
      m_ps = ps | 32'h10;
      ew = 1'b1;
      if (ps[4]) begin m_depc = pc; ev = 4'b0100; end
      else begin m_epc1 = pc; ev = ps[5] ? 4'b0010 : 4'b0001; end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag, ev, ew);
    gen_req = 1'b0; dbg_req = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    compare_all("R9", 4'b0000, 1'b0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "reset vec_sel", {28'd0, vec_sel}, 32'd0);
    chk("R1", "reset ps_we", {31'd0, ps_we}, 32'd0);
    chk("R1", "reset epc1", epc1, 32'd0);
    chk("R1", "reset depc", depc, 32'd0);
    chk("R1", "reset eps_dbg", eps_dbg, 32'd0);
    chk("R1", "reset ps_out", ps_out, 32'd0);

    // general route sweep: exception mode, user mode, address valid, causes
    for (int e = 0; e < 2; e++)
      for (int u = 0; u < 2; u++)
        for (int h = 0; h < 2; h++)
          for (int c = 0; c < 64; c += 9) begin
            logic [31:0] ps;
            ps = 32'hA500_0000 | (32'(u) << 5) | (32'(e) << 4) | 32'(c & 15);
            run(e ? "R3" : "R2", 1'b1, 6'(c), h[0], 32'hF000_0000 + 32'(c * 77 + h),
                1'b0, 6'd0, 32'h4000_0000 + 32'(c * 4 + e * 2 + u), ps);
          end
    idle();

    // back-to-back general requests
    run("R9", 1'b1, 6'd3, 1'b1, 32'h1234_5678, 1'b0, 6'd0, 32'h100, 32'h0);
    run("R9", 1'b1, 6'd4, 1'b0, 32'h9999_9999, 1'b0, 6'd0, 32'h104, 32'h10);
    idle();

    // debug route alone across every interrupt level
    for (int l = 0; l < 16; l++)
      for (int m = 0; m < 4; m++) begin
        run("R6", 1'b0, 6'd0, 1'b0, 32'h0, 1'b1, 6'(l * 4 + m),
            32'h8000_0000 + 32'(l * 16 + m), 32'h0300_0000 | (32'(m) << 4) | 32'(l));
        idle();
      end

    // both routes in the same cycle
    for (int l = 0; l < 16; l++)
      for (int m = 0; m < 4; m++)
        run("R10", 1'b1, 6'(63 - l), m[0], 32'hCAFE_0000 + 32'(l), 1'b1, 6'(l),
            32'h2000_0000 + 32'(l * 8 + m), (32'(m) << 4) | 32'(l));
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule